// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR SDRAM out of power-up. After it accepts a start pulse it raises the clock enable and holds NOP for a fixed pause. It then issues one precharge-all command, eight auto-refresh commands and one load-mode command, and enters normal mode. From then on it issues an auto-refresh each time a refresh timer expires. The command bus here is driven only by the sequencer. Data paths and bank management belong to the surrounding controller.

A 32-bit configuration word carries the device geometry, CAS latency, bus width and timing counts. The block latches this word when it accepts the start pulse. The block also reports the memory size in bytes, computed combinationally from the geometry and the bus width of the live configuration word. The pause length in cycles is derived from the clock frequency and pause-time parameters: `PAUSE_CYC = CLK_FREQ_HZ / 1_000_000 * PAUSE_US`.

Top module: `sdram_init_seq`

## Requirements
- R1: Reset state:
  - `cke_o` is low.
  - All four command pins are high (deselect).
  - `init_done_o` is low.
- R2: Accepting a start pulse:
  - A start pulse with a legal CAS field (2 or 3) is accepted in the idle state.
  - From the next cycle (offset 0), `cke_o` is high and the pins read NOP: `{cs_n,ras_n,cas_n,we_n}` = 0111.
  - The pins stay at NOP until offset `PAUSE_CYC`.
- R3: At offset `PAUSE_CYC` the block issues precharge-all for one cycle: pins 0010, with address bit 10 high.
- R4: Init refreshes:
  - Exactly eight auto-refresh commands (pins 0001) follow.
  - The first comes `max(tRP,2)` cycles after the precharge.
  - Each later one comes `max(tRC,2)` cycles after the one before it.
- R5: Load mode:
  - A load-mode command (pins 0000) comes `max(tRC,2)` cycles after the eighth refresh.
  - Bank pins are 0.
  - Address bits [6:4] carry the CAS latency; every other address bit is 0.
  - This gives burst length 1, sequential burst type and write bursts as programmed.
- R6: Normal mode:
  - Normal mode begins 2 cycles after the load-mode command.
  - `init_done_o` rises one cycle after normal mode begins and stays high until reset.
- R7: Periodic refresh:
  - With refresh period P (P ≥ 2), the refresh timer expires at offsets kP−1 for k ≥ 1.
  - An expiry seen in normal mode issues an auto-refresh on the next cycle.
  - Expiries before normal mode are dropped without effect.
  - The pins read NOP at all other times.
- R8: A start pulse has no effect when:
  - the CAS field is not 2 or 3, or
  - the sequence is already running, or
  - initialization is done.
- R9: Configuration word layout. The width and bank fields are offset-coded.

  | Bits | Field | Coding |
  |---|---|---|
  | [1:0] | column bits | value − 8 |
  | [3:2] | row bits | value − 11 |
  | [4] | bank bits | value − 1 |
  | [6:5] | CAS latency | as is |
  | [10:7] | tWR | cycles |
  | [14:11] | tRC | cycles |
  | [18:15] | tRP | cycles |
  | [22:19] | tRCD | cycles |
  | [26:23] | tRAS | cycles |
  | [30:27] | tXSR | cycles |
  | [31] | bus width | 1 = 16-bit, 0 = 32-bit |

- R10: `mem_size_o` equals:
  - 2^(row+col+bank+1) for a 16-bit bus;
  - 2^(row+col+bank+2) for a 32-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for the power-up sequence |
| cfg_i | input | 32 | Configuration word (R9 layout) |
| refresh_period_i | input | RP_W | Cycles between normal-mode refreshes |
| cke_o | output | 1 | SDRAM clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | SDRAM address pins |
| ba_o | output | BA_W | SDRAM bank pins |
| init_done_o | output | 1 | High once normal mode is reached |
| mem_size_o | output | SIZE_W | Memory size in bytes |

## Verification
The hardest case is the boundary between initialization and normal mode. There, a refresh expiry can land in the load-mode wait and be dropped, while the very next expiry must produce a command. The bench sweeps two refresh periods, a short one and a long one, against several tRP and tRC values, which moves that boundary across the expiry grid. It then compares every cycle of the command pins with an arithmetic model of the schedule. Extra start pulses are injected during the pause and again after normal mode begins, so the ignored-start case is seen in the same trace.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef struct packed {
    logic       bus16;
    logic [3:0] t_xsr;
    logic [3:0] t_ras;
    logic [3:0] t_rcd;
    logic [3:0] t_rp;
    logic [3:0] t_rc;
    logic [3:0] t_wr;
    logic [1:0] cas;
    logic       bank_off;
    logic [1:0] row_off;
    logic [1:0] col_off;
  } sdram_cfg_t;

  localparam int CFG_W = $bits(sdram_cfg_t);

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_PRE   = 4'b0010;
  localparam logic [3:0] CMD_REF   = 4'b0001;
  localparam logic [3:0] CMD_LMR   = 4'b0000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PAUSE, ST_PRE, ST_TRP, ST_REF, ST_TRC,
    ST_LMR, ST_TMRD, ST_RUN, ST_RREF
  } seq_state_e;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // next command may follow when two or fewer cycles remain
  assign expire_o = (cnt_q <= CNT_W'(2));

  AST_GAP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));  // R4
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int RP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [RP_W-1:0] period_i,
  output logic            due_o
);
  logic [RP_W-1:0] rcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rcnt_q <= '0;
    else if (!run_i)          rcnt_q <= period_i - 1'b1;
    else if (rcnt_q == '0)    rcnt_q <= period_i - 1'b1;
    else                      rcnt_q <= rcnt_q - 1'b1;
  end

  assign due_o = run_i && (rcnt_q == '0);

  AST_REF_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_o && run_i) |=> (rcnt_q == $past(period_i) - 1'b1));  // R7
endmodule

// File: rtl/sdram_size_calc.sv
module sdram_size_calc
  import sdram_init_pkg::*;
#(
  parameter int SIZE_W = 32
) (
  input  sdram_cfg_t        cfg_i,
  output logic [SIZE_W-1:0] size_o
);
  logic [5:0] exp_w;

  always_comb begin
    exp_w = 6'd11 + 6'(cfg_i.row_off) + 6'd8 + 6'(cfg_i.col_off)
          + 6'd1 + 6'(cfg_i.bank_off) + (cfg_i.bus16 ? 6'd1 : 6'd2);
    size_o = SIZE_W'(1) << exp_w;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int PAUSE_US    = 200,
  parameter int INIT_REFS   = 8,
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int RP_W        = 16,
  parameter int SIZE_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       cfg_i,
  input  logic [RP_W-1:0]   refresh_period_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              init_done_o,
  output logic [SIZE_W-1:0] mem_size_o
);
  localparam int PAUSE_CYC = CLK_FREQ_HZ / 1_000_000 * PAUSE_US;
  localparam int CNT_W     = $clog2(PAUSE_CYC + 16) + 1;
  localparam int RC_W      = $clog2(INIT_REFS + 1);
  localparam int TMRD      = 2;

  sdram_cfg_t  cfg_w, cfg_q;
  seq_state_e  state_q, state_d;
  logic [RC_W-1:0]  ref_cnt_q;
  logic             gap_load, gap_exp, ref_due, start_ok, done_q;
  logic [CNT_W-1:0] gap_val;
  logic [3:0]       cmd;
  logic             unused_cfg;

  assign cfg_w = sdram_cfg_t'(cfg_i[CFG_W-1:0]);
  assign unused_cfg = ^{cfg_q.t_wr, cfg_q.t_rcd, cfg_q.t_ras, cfg_q.t_xsr,
                        cfg_q.bus16, cfg_q.bank_off, cfg_q.row_off, cfg_q.col_off};
  assign start_ok = start_i && (state_q == ST_IDLE) &&
                    (cfg_w.cas == 2'd2 || cfg_w.cas == 2'd3);

  sdram_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_load), .load_val_i(gap_val), .expire_o(gap_exp));

  sdram_refresh_timer #(.RP_W(RP_W)) u_rfsh (
    .clk_i, .rst_ni, .run_i(state_q != ST_IDLE), .period_i(refresh_period_i),
    .due_o(ref_due));

  sdram_size_calc #(.SIZE_W(SIZE_W)) u_size (.cfg_i(cfg_w), .size_o(mem_size_o));

  always_comb begin
    gap_load = 1'b0;
    gap_val  = '0;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) begin
                  state_d = ST_PAUSE; gap_load = 1'b1; gap_val = CNT_W'(PAUSE_CYC + 1);
                end
      ST_PAUSE: if (gap_exp) state_d = ST_PRE;
      ST_PRE:   begin state_d = ST_TRP; gap_load = 1'b1; gap_val = CNT_W'(cfg_q.t_rp); end
      ST_TRP:   if (gap_exp) state_d = ST_REF;
      ST_REF:   begin state_d = ST_TRC; gap_load = 1'b1; gap_val = CNT_W'(cfg_q.t_rc); end
      ST_TRC:   if (gap_exp) state_d = (ref_cnt_q == RC_W'(INIT_REFS)) ? ST_LMR : ST_REF;
      ST_LMR:   begin state_d = ST_TMRD; gap_load = 1'b1; gap_val = CNT_W'(TMRD); end
      ST_TMRD:  if (gap_exp) state_d = ST_RUN;
      ST_RUN:   if (ref_due) state_d = ST_RREF;
      ST_RREF:  state_d = ST_RUN;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      ref_cnt_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) cfg_q <= cfg_w;
      if (state_q == ST_PRE)      ref_cnt_q <= '0;
      else if (state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
      if (state_q == ST_RUN) done_q <= 1'b1;
    end
  end

  always_comb begin
    addr_o = '0;
    ba_o   = '0;
    unique case (state_q)
      ST_IDLE:         cmd = CMD_DESEL;
      ST_PRE:          begin cmd = CMD_PRE; addr_o[10] = 1'b1; end
      ST_REF, ST_RREF: cmd = CMD_REF;
      ST_LMR:          begin cmd = CMD_LMR; addr_o[6:4] = {1'b0, cfg_q.cas}; end
      default:         cmd = CMD_NOP;
    endcase
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd;
  assign cke_o       = (state_q != ST_IDLE);
  assign init_done_o = done_q;

  AST_LMR_CAS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LMR) |-> (cfg_q.cas == 2'd2 || cfg_q.cas == 2'd3));  // R8
  AST_LMR_BANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && {cs_no, ras_no, cas_no, we_no} == CMD_LMR) |-> (ba_o == '0));  // R5
  AST_LMR_AFTER_REFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LMR) |-> (ref_cnt_q == RC_W'(INIT_REFS)));  // R4
  AST_CKE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);  // R2
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);  // R6
  AST_DONE_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> $past(state_q == ST_RUN));  // R6
endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int PAUSE = 200;
  localparam int RP_W  = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [RP_W-1:0] refresh_period_i = 16'd10;
  logic cke_o, cs_no, ras_no, cas_no, we_no, init_done_o;
  logic [12:0] addr_o;
  logic [1:0]  ba_o;
  logic [31:0] mem_size_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  sdram_init_seq #(.CLK_FREQ_HZ(1_000_000), .PAUSE_US(PAUSE)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // R9 layout
  function automatic logic [31:0] mk_cfg(int col, int row, int bank, int cas,
                                         int rp, int rc, bit b16);
    logic [31:0] c = '0;
    c[1:0] = 2'(col - 8); c[3:2] = 2'(row - 11); c[4] = 1'(bank - 1);
    c[6:5] = 2'(cas); c[14:11] = 4'(rc); c[18:15] = 4'(rp); c[31] = b16;
    c[10:7] = 4'd3; c[22:19] = 4'd2; c[26:23] = 4'd5; c[30:27] = 4'd9;
    return c;
  endfunction

  function automatic int gmax(int t);
    return (t < 2) ? 2 : t;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic run_trace(int cas, int rp, int rc, int per);
    int r0, lmr, run0, total;
    logic [3:0] exp, act;
    string req;
    r0 = PAUSE + gmax(rp); lmr = r0 + 8 * gmax(rc); run0 = lmr + 2;
    total = run0 + 3 * per + 10;
    cfg_i = mk_cfg(9, 12, 2, cas, rp, rc, 1'b0);
    refresh_period_i = RP_W'(per);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n <= total; n++) begin
      exp = 4'b0111; req = (n < PAUSE) ? "R2" : (n >= run0) ? "R7" : "R4";
      if (n == PAUSE) begin exp = 4'b0010; req = "R3"; end
      for (int i = 0; i < 8; i++) if (n == r0 + i * gmax(rc)) begin exp = 4'b0001; req = "R4"; end
      if (n == lmr) begin exp = 4'b0000; req = "R5"; end
      if (n >= run0 + 1 && (n % per) == 0) begin exp = 4'b0001; req = "R7"; end
      act = {cs_no, ras_no, cas_no, we_no};
      chk(act == exp && cke_o, req, $sformatf("cmd at offset %0d", n), {cke_o, act}, {1'b1, exp});
      chk(init_done_o == (n >= run0 + 1), "R6", $sformatf("done at offset %0d", n),
          init_done_o, (n >= run0 + 1));
      if (n == PAUSE) chk(addr_o[10], "R3", "precharge A10", addr_o, 13'h400);
      if (n == lmr)
        chk(addr_o == 13'(cas << 4) && ba_o == 2'd0, "R5", "mode addr/bank",
            {ba_o, addr_o}, 15'(cas << 4));
      // R8: start pulses mid-pause and in normal mode must not disturb the trace
      start_i = (n == 50) || (n == run0 + 3);
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int rp_v[3] = '{0, 1, 4};
    int rc_v[2] = '{2, 7};
    int per_v[2] = '{5, 41};
    int e;
    do_reset();
    // R1
    chk(!cke_o && {cs_no, ras_no, cas_no, we_no} == 4'hF && !init_done_o, "R1",
        "reset outputs", {cke_o, cs_no, ras_no, cas_no, we_no, init_done_o}, 6'b011110);
    // R10 / R9 sweep over geometry and bus width
    for (int b16 = 0; b16 < 2; b16++)
      for (int c = 8; c < 12; c++)
        for (int r = 11; r < 15; r++)
          for (int bk = 1; bk < 3; bk++) begin
            cfg_i = mk_cfg(c, r, bk, 2, 1, 1, 1'(b16));
            @(negedge clk_i);
            e = r + c + bk + (b16 ? 1 : 2);
            chk(mem_size_o == (32'd1 << e), "R10", "mem size", mem_size_o, 32'd1 << e);
          end
    // R8: illegal CAS latency ignored
    for (int cs = 0; cs < 2; cs++) begin
      do_reset();
      cfg_i = mk_cfg(9, 12, 2, cs, 1, 2, 1'b0);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (5) @(negedge clk_i);
      chk(!cke_o && {cs_no, ras_no, cas_no, we_no} == 4'hF, "R8", "bad CAS start",
          {cke_o, cs_no, ras_no, cas_no, we_no}, 5'b01111);
    end
    // main schedule sweep: R2..R8
    for (int cas = 2; cas < 4; cas++)
      foreach (rp_v[i])
        foreach (rc_v[j])
          foreach (per_v[k]) begin
            do_reset();
            run_trace(cas, rp_v[i], rc_v[j], per_v[k]);
          end
    finish_up();
  end
endmodule